// File: doc/BRIEF.md
# Dual-Halfword Saturating Vector Shifter

This unit shifts a 32-bit word as two separate signed 16-bit lanes, both by one 5-bit immediate that is read as a signed count. Non-negative counts shift left, and a lane that cannot hold its shifted value clamps to the largest value of its own sign. Negative counts (immediate values 0x10 to 0x1F) shift right arithmetically by 16 minus the low four bits of the immediate.

Alongside the packed result, the unit takes in a 32-bit status word and returns it updated. The zero, negative, overflow, overflow-copy and sticky-overflow bits are recomputed from both lanes. Every other bit passes through unchanged.

Result and status are registered, so they appear one clock after the operands are presented. Reset is synchronous and active-low.

Top module: `vsh_dual_shift`

## Requirements
- R1: The upper lane is bits [31:16] and the lower lane is bits [15:0]. Each lane is shifted on its own and returned in the same position, so one lane's saturation never alters the other lane.
- R2: When amount bit 4 is 0, both lanes shift left by amount[3:0]. When amount bit 4 is 1, both lanes shift right by 16 minus amount[3:0], so 0x10 shifts by 16 and 0x1F shifts by 1.
- R3: Right shifts are arithmetic: the lane's sign bit fills every vacated position. For example, 0xB0B4 shifted by amount 0x19 gives 0xFF61, and 0x8000 shifted by amount 0x18 gives 0xFF80.
- R4: A left shift that would lose a significant bit or change the sign of a lane clamps that lane. A non-negative lane becomes 0x7FFF and a negative lane becomes 0x8000.
- R5: An amount of zero returns both lanes unchanged.
- R6: Status bit 0 (zero) is set when at least one result lane equals 0x0000, and is cleared otherwise.
- R7: Status bit 1 (negative) is set when at least one result lane has bit 15 set, and is cleared otherwise.
- R8: Status bit 2 (overflow) and bit 4 (overflow copy) are set when any lane clamped, and are cleared otherwise. Status bit 3 (sticky overflow) is set when a lane clamps and keeps its incoming value otherwise, so this unit never clears it.
- R9: Status bits other than 0 to 4 leave the unit exactly as they came in.
- R10: Result and status are registered with one clock of latency. A clock edge with rst_n low clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Packed pair of signed 16-bit operands |
| amt_i | input | 5 | Signed shift immediate |
| stat_i | input | 32 | Incoming status word |
| res_o | output | 32 | Packed shifted lanes |
| stat_o | output | 32 | Updated status word |

## Verification
The assertions assume that the operands and status word are stable, known values at every rising edge after reset. They also assume that the previous cycle's inputs are the ones the registered outputs reflect, which holds only once a full cycle has passed out of reset; a local flag gates the checks that look back one cycle. The stimulus changes inputs only on falling edges and always drives defined values. It mixes random lanes with forced edge values (0x0000, 0x7FFF, 0x8000, 0xFFFF) across all 32 immediates, and random status words with both settings of the sticky bit.

// File: rtl/vsh_pkg.sv
`timescale 1ns/1ps
// Package vsh_pkg
// Holds the shared sizes and the status-word bit layout of the dual-lane
// shifter. Assumes a lane width equal to 2**(AMT_W-1) so the magnitude
// field of the immediate spans one full lane.
package vsh_pkg;
    parameter int LANE_W = 16;
    parameter int LANES  = 2;
    parameter int AMT_W  = 5;
    parameter int STAT_W = 32;
    localparam int DATA_W = LANE_W * LANES;

    // Status word bit positions owned by the shifter.
    parameter int ZF_BIT  = 0;
    parameter int NF_BIT  = 1;
    parameter int VF_BIT  = 2;
    parameter int VS_BIT  = 3;
    parameter int VC_BIT  = 4;
endpackage

// File: rtl/vsh_lane.sv
`timescale 1ns/1ps
// Module vsh_lane
// Shifts one signed lane by a signed immediate. Non-negative counts shift
// left with signed clamping; negative counts shift right arithmetically by
// W minus the magnitude field. Purely combinational.
// Assumes W == 2**(CW-1).
module vsh_lane #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  x_i,
    input  logic [CW-1:0] amt_i,
    output logic [W-1:0]  y_o,
    output logic          sat_o
);
    localparam int MW = CW - 1;

    logic [2*W-1:0] ext_l;
    logic [W:0]     head;
    logic           fits;
    logic [CW-1:0]  rcnt;
    logic [W-1:0]   rsh;

    // Left path: widen with sign, shift, and test that no significant bit left the lane.
    always_comb begin
        ext_l = {{W{x_i[W-1]}}, x_i} << amt_i[MW-1:0];
        head  = ext_l[2*W-1:W-1];
        fits  = (head == {(W+1){1'b0}}) || (head == {(W+1){1'b1}});
    end

    // Right path: arithmetic shift by W minus the magnitude field.
    always_comb begin
        rcnt = CW'(W) - CW'(amt_i[MW-1:0]);
        rsh  = W'($signed(x_i) >>> rcnt);
    end

    // Select direction and apply clamping.
    always_comb begin
        sat_o = 1'b0;
        if (amt_i[CW-1]) begin
            y_o = rsh;
        end else if (fits) begin
            y_o = ext_l[W-1:0];
        end else begin
            sat_o = 1'b1;
            y_o   = x_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/vsh_flags.sv
`timescale 1ns/1ps
// Module vsh_flags
// Builds the next status word from the shifted lanes and their clamp
// indications. Owns the zero, negative, overflow, overflow-copy and sticky
// bits; forwards the rest. Purely combinational.
module vsh_flags
    import vsh_pkg::*;
#(
    parameter int N  = LANES,
    parameter int W  = LANE_W,
    parameter int SW = STAT_W
) (
    input  logic [N*W-1:0] res_i,
    input  logic [N-1:0]   sat_i,
    input  logic [SW-1:0]  st_i,
    output logic [SW-1:0]  st_o
);
    logic any_zero;
    logic any_neg;
    logic any_sat;

    // Reduce per-lane conditions to single indications.
    always_comb begin
        any_zero = 1'b0;
        any_neg  = 1'b0;
        for (int k = 0; k < N; k++) begin
            any_zero = any_zero | (res_i[k*W +: W] == {W{1'b0}});
            any_neg  = any_neg  | res_i[k*W + W - 1];
        end
        any_sat = |sat_i;
    end

    // Merge the new flags into the forwarded status word.
    always_comb begin
        st_o         = st_i;
        st_o[ZF_BIT] = any_zero;
        st_o[NF_BIT] = any_neg;
        st_o[VF_BIT] = any_sat;
        st_o[VC_BIT] = any_sat;
        st_o[VS_BIT] = st_i[VS_BIT] | any_sat;
    end
endmodule

// File: rtl/vsh_dual_shift.sv
`timescale 1ns/1ps
// Module vsh_dual_shift
// Top of the dual-halfword saturating shifter: one lane shifter per lane,
// a flag merger, and an output register stage (one clock of latency,
// synchronous active-low reset clearing both outputs).
module vsh_dual_shift
    import vsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [DATA_W-1:0] res_o,
    output logic [STAT_W-1:0] stat_o
);
    logic [DATA_W-1:0] res_c;
    logic [LANES-1:0]  sat_c;
    logic [STAT_W-1:0] stat_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vsh_lane #(.W(LANE_W), .CW(AMT_W)) u_lane (
            .x_i   (src_i[g*LANE_W +: LANE_W]),
            .amt_i (amt_i),
            .y_o   (res_c[g*LANE_W +: LANE_W]),
            .sat_o (sat_c[g])
        );
    end

    vsh_flags #(.N(LANES), .W(LANE_W), .SW(STAT_W)) u_flags (
        .res_i (res_c),
        .sat_i (sat_c),
        .st_i  (stat_i),
        .st_o  (stat_c)
    );

    // Register the packed result and the updated status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o  <= '0;
            stat_o <= '0;
        end else begin
            res_o  <= res_c;
            stat_o <= stat_c;
        end
    end
endmodule

// File: rtl/vsh_dual_shift_chk.sv
`timescale 1ns/1ps
// Module vsh_dual_shift_chk
// Property checker bound to vsh_dual_shift. Relates registered outputs to
// the inputs of the previous cycle; checks that look back are gated until
// one full cycle out of reset has passed.
module vsh_dual_shift_chk
    import vsh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] src_i,
    input logic [AMT_W-1:0]  amt_i,
    input logic [STAT_W-1:0] stat_i,
    input logic [DATA_W-1:0] res_o,
    input logic [STAT_W-1:0] stat_o
);
    localparam logic [STAT_W-1:0] OWNED =
        (STAT_W'(1) << ZF_BIT) | (STAT_W'(1) << NF_BIT) | (STAT_W'(1) << VF_BIT) |
        (STAT_W'(1) << VS_BIT) | (STAT_W'(1) << VC_BIT);

    logic prev_run;

    // Note whether the previous edge was a working (non-reset) cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_run <= 1'b0;
        else        prev_run <= 1'b1;
    end

    p_copy_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[VF_BIT] == stat_o[VC_BIT]);

    p_ovf_implies_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[VF_BIT] |-> stat_o[VS_BIT]);

    p_sticky_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_run && $past(stat_i[VS_BIT])) |-> stat_o[VS_BIT]);

    p_right_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_run && $past(amt_i[AMT_W-1])) |-> !stat_o[VF_BIT]);

    p_zero_amount_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_run && $past(amt_i) == '0) |-> (res_o == $past(src_i) && !stat_o[VF_BIT]));

    p_other_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prev_run |-> ((stat_o & ~OWNED) == ($past(stat_i) & ~OWNED)));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prev_run |-> (stat_o[ZF_BIT] ==
            ((res_o[LANE_W-1:0] == '0) || (res_o[DATA_W-1:LANE_W] == '0))));

    p_neg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prev_run |-> (stat_o[NF_BIT] == (res_o[LANE_W-1] || res_o[DATA_W-1])));
endmodule

bind vsh_dual_shift vsh_dual_shift_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .amt_i  (amt_i),
    .stat_i (stat_i),
    .res_o  (res_o),
    .stat_o (stat_o)
);

// File: tb/sim_vsh_dual_shift.sv
`timescale 1ns/1ps
// Bench for vsh_dual_shift: directed corner cases plus seeded random
// vectors, compared against bit-serial reference functions.
module sim_vsh_dual_shift;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [4:0]  amt_i = '0;
    logic [31:0] stat_i = '0;
    logic [31:0] res_o;
    logic [31:0] stat_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    vsh_dual_shift u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .amt_i(amt_i),
        .stat_i(stat_i), .res_o(res_o), .stat_o(stat_o)
    );

    always #2.5 clk = ~clk;

    // Reference for one lane: one bit per step, clamping on any sign change (R2 R3 R4).
    function automatic logic [15:0] ref_lane(input logic [15:0] x, input logic [4:0] a,
                                             output logic s);
        logic [15:0] v;
        int n;
        v = x;
        s = 1'b0;
        if (a[4]) begin
            n = 16 - int'(a[3:0]);
            for (int i = 0; i < n; i++) v = {v[15], v[15:1]};
        end else begin
            for (int i = 0; i < int'(a[3:0]); i++) begin
                if (v[15] != v[14]) s = 1'b1;
                v = {v[14:0], 1'b0};
            end
            if (s) v = x[15] ? 16'h8000 : 16'h7FFF;
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Present one operation on a falling edge and check one cycle later (R10).
    task automatic apply(input string tag, input logic [31:0] s, input logic [4:0] a,
                         input logic [31:0] st);
        logic [15:0] hi, lo;
        logic sh, sl;
        logic [31:0] est;
        hi = ref_lane(s[31:16], a, sh);
        lo = ref_lane(s[15:0], a, sl);
        est = st;
        est[0] = (hi == 16'h0) || (lo == 16'h0);
        est[1] = hi[15] || lo[15];
        est[2] = sh || sl;
        est[4] = sh || sl;
        est[3] = st[3] || sh || sl;
        @(negedge clk);
        src_i = s; amt_i = a; stat_i = st;
        @(negedge clk);
        check(tag, res_o, {hi, lo});
        check("status R6 R7 R8 R9", stat_o, est);
    endtask

    function automatic logic [15:0] pick_lane();
        case ($urandom_range(0, 7))
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        src_i = 32'h1234_5678; amt_i = 5'd3; stat_i = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset result", res_o, 32'h0);
        check("R10 reset status", stat_o, 32'h0);
        rst_n = 1'b1;

        apply("R3 right 7", 32'hB0B4_0000, 5'h19, 32'h0000_0000);
        apply("R3 right 8", 32'h0000_8000, 5'h18, 32'h0000_0008);
        apply("R2 right 15", 32'hF610_FFFF, 5'h11, 32'h3410_4410);
        apply("R2 right 9", 32'h3F5C_8AF5, 5'h17, 32'h6CD0_C69F);
        apply("R2 right 10", 32'h7FFF_FFFF, 5'h16, 32'hFFFF_FFE0);
        apply("R2 right 4", 32'h708B_B53F, 5'h1C, 32'h0);
        apply("R2 right 1", 32'h3563_CFA3, 5'h1F, 32'h0);
        apply("R2 right 16", 32'h8001_7FFF, 5'h10, 32'h0);
        apply("R4 clamp pos", 32'h4000_0001, 5'd1, 32'h0);
        apply("R4 clamp neg", 32'h8000_8001, 5'd1, 32'h0);
        apply("R4 edge fits", 32'hC000_2000, 5'd1, 32'h0);
        apply("R4 max left", 32'h0001_FFFF, 5'd15, 32'h0);
        apply("R1 lane isolation", 32'h7FFF_0001, 5'd3, 32'h0);
        apply("R5 zero amount", 32'h8000_0000, 5'd0, 32'hFFFF_FFE0);
        apply("R8 sticky kept", 32'h0101_0202, 5'd2, 32'h0000_0008);
        apply("R9 passthru", 32'h1111_2222, 5'd4, 32'hA5A5_A5A0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] s;
            logic [4:0] a;
            s = {pick_lane(), pick_lane()};
            a = 5'($urandom_range(0, 31));
            apply(a == 5'd0 ? "R5 random" : (a[4] ? "R3 random" : "R4 random"),
                  s, a, $urandom);
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset again result", res_o, 32'h0);
        check("R10 reset again status", stat_o, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule